// File: doc/BRIEF.md
# Fractional Baud-Rate Tick Generator

This block turns the system clock into the oversampling clock enable that a serial transmitter and receiver share. Two dividers are chained. A fractional prescaler comes first. Its ratio is an 8-bit value that is read as a fixed-point number with three fraction bits, so it divides by any multiple of one eighth from 1.0 up to 31.875. A 16-bit integer divisor follows. Software loads the divisor one byte at a time into two byte-wide latches.

Every pulse of the divisor is one oversampling tick. Every sixteenth tick, by default, the block also raises a bit-rate strobe. A transmitter can wait for that strobe before it starts a frame, so the start is delayed by no more than one bit period. Any write to the divisor or to the prescaler restarts the integer counter on the next clock edge. This means a new rate takes effect at once and does not first finish a long count at the old rate.

Top module: `baud_tick_gen`

## Requirements
- R1: While `rst` is high, both `os_tick` and `baud_stb` are low. Reset loads divisor 1 and prescaler code 8, so from shortly after reset `os_tick` is high on every cycle.
- R2: With prescaler code 8, `os_tick` pulses once every D clocks, where D is the divisor.
- R3: `cfg_sel` = 0 writes the divisor low byte and `cfg_sel` = 1 writes the high byte. The divisor is {high, low}, so divisors above 255 divide exactly.
- R4: A divisor write restarts the count. With prescaler code 8, the first `os_tick` after a divisor write comes D+1 clock edges after the edge that captured the write.
- R5: `cfg_sel` = 2 writes prescaler code P, which gives a divide ratio of P/8. In any window of D*P consecutive clocks, exactly 8 ticks occur. Consecutive ticks are either floor(D*P/8) or ceil(D*P/8) clocks apart.
- R6: A prescaler code below 8 acts as code 8, which means divide by 1.
- R7: A divisor of 1 gives a tick on every prescaler pulse. A divisor of 0 acts as 1.
- R8: `baud_stb` is high only in a cycle in which `os_tick` is high. It marks every OVS-th tick (OVS = 16 by default), counted from the last configuration write.
- R9: A write with `cfg_sel` = 3 changes nothing: the tick phase and period carry on unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_wr | input | 1 | Configuration write strobe, one cycle per write |
| cfg_sel | input | 2 | Target: 0 divisor low, 1 divisor high, 2 prescaler, 3 none |
| cfg_data | input | 8 | Write data |
| os_tick | output | 1 | Oversampling clock enable, one cycle wide |
| baud_stb | output | 1 | Bit-rate strobe, coincides with every OVS-th tick |

## Verification
A fault in the fractional accumulator appears as a wrong tick count within a single window of D*P clocks. It also shows as an uneven spacing between two neighbouring ticks. A divisor counter that loads the wrong value shows up at the first tick after a write, which lands at the wrong clock edge. That reload check therefore catches both off-by-one errors and a missing restart within D+1 cycles. A baud strobe counter that is off by one, or that is not cleared, shows up by the sixteenth tick after a write.

// File: rtl/baud_gen_pkg.sv
package baud_gen_pkg;
  typedef enum logic [1:0] {
    SEL_DIV_LO   = 2'd0,
    SEL_DIV_HI   = 2'd1,
    SEL_PRESCALE = 2'd2,
    SEL_NONE     = 2'd3
  } cfg_sel_e;
endpackage

// File: rtl/frac_prescaler.sv
// Fractional prescaler: adds 2**FRAC_W each clock and fires when the sum
// reaches the limit, keeping the remainder so the average ratio is limit/2**FRAC_W.
module frac_prescaler #(
  parameter int PRE_W  = 8,
  parameter int FRAC_W = 3
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             clr,
  input  logic [PRE_W-1:0] limit,
  output logic             ce_o
);
  localparam int ACC_W = PRE_W + 1;
  localparam logic [ACC_W-1:0] STEP = ACC_W'(1 << FRAC_W);

  logic [ACC_W-1:0] acc_q;
  logic [ACC_W-1:0] sum;
  logic [ACC_W-1:0] lim_ext;
  logic             ce_q;

  assign lim_ext = {1'b0, limit};
  assign sum     = acc_q + STEP;

  always_ff @(posedge clk) begin
    if (rst || clr) begin
      acc_q <= '0;
      ce_q  <= 1'b0;
    end else if (sum >= lim_ext) begin
      acc_q <= sum - lim_ext;
      ce_q  <= 1'b1;
    end else begin
      acc_q <= sum;
      ce_q  <= 1'b0;
    end
  end

  assign ce_o = ce_q;

  // R5: the remainder always stays below the limit
  a_r5_acc_below_limit: assert property (@(posedge clk) disable iff (rst)
    acc_q < lim_ext);
endmodule

// File: rtl/div_counter.sv
// Integer divider: counts prescaler enables down from div_val-1 to zero.
module div_counter #(
  parameter int DIV_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             ce,
  input  logic             reload,
  input  logic [DIV_W-1:0] div_val,
  output logic             tick_now,
  output logic             tick_o
);
  logic [DIV_W-1:0] cnt_q;
  logic             tick_q;

  assign tick_now = ce && (cnt_q == '0) && !reload;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q  <= '0;
      tick_q <= 1'b0;
    end else begin
      tick_q <= tick_now;
      if (reload)
        cnt_q <= div_val - DIV_W'(1);
      else if (ce)
        cnt_q <= (cnt_q == '0) ? div_val - DIV_W'(1) : cnt_q - DIV_W'(1);
    end
  end

  assign tick_o = tick_q;

  // R7: a tick only follows a prescaler enable
  a_r7_tick_on_enable: assert property (@(posedge clk) disable iff (rst)
    tick_o |-> $past(ce));
  // R4: the reload edge never emits a tick
  a_r4_no_tick_on_reload: assert property (@(posedge clk) disable iff (rst)
    reload |=> !tick_o);
endmodule

// File: rtl/baud_strobe.sv
// Marks every OVS-th oversampling tick.
module baud_strobe #(
  parameter int OVS = 16
) (
  input  logic clk,
  input  logic rst,
  input  logic clr,
  input  logic tick_now,
  output logic baud_o
);
  localparam int CW = (OVS > 1) ? $clog2(OVS) : 1;
  localparam logic [CW-1:0] LAST = CW'(OVS - 1);

  logic [CW-1:0] bcnt_q;
  logic          baud_q;

  always_ff @(posedge clk) begin
    if (rst || clr) begin
      bcnt_q <= '0;
      baud_q <= 1'b0;
    end else begin
      baud_q <= tick_now && (bcnt_q == LAST);
      if (tick_now)
        bcnt_q <= (bcnt_q == LAST) ? '0 : bcnt_q + CW'(1);
    end
  end

  assign baud_o = baud_q;

  // R8: the tick counter never passes the last position
  a_r8_count_in_range: assert property (@(posedge clk) disable iff (rst)
    bcnt_q <= LAST);
endmodule

// File: rtl/baud_tick_gen.sv
module baud_tick_gen #(
  parameter int BYTE_W = 8,
  parameter int FRAC_W = 3,
  parameter int OVS    = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cfg_wr,
  input  logic [1:0]        cfg_sel,
  input  logic [BYTE_W-1:0] cfg_data,
  output logic              os_tick,
  output logic              baud_stb
);
  import baud_gen_pkg::*;

  localparam int DIV_W = 2 * BYTE_W;
  localparam logic [BYTE_W-1:0] PRE_UNITY = BYTE_W'(1 << FRAC_W);

  cfg_sel_e          sel;
  logic [BYTE_W-1:0] div_lo_q, div_hi_q, pre_q;
  logic              reload_q;
  logic [DIV_W-1:0]  div_raw, div_eff;
  logic [BYTE_W-1:0] pre_eff;
  logic              pre_clr;
  logic              ce;
  logic              tick_now;

  assign sel = cfg_sel_e'(cfg_sel);

  always_ff @(posedge clk) begin
    if (rst) begin
      div_lo_q <= BYTE_W'(1);
      div_hi_q <= '0;
      pre_q    <= PRE_UNITY;
      reload_q <= 1'b0;
    end else begin
      reload_q <= cfg_wr && (sel != SEL_NONE);
      if (cfg_wr) begin
        case (sel)
          SEL_DIV_LO:   div_lo_q <= cfg_data;
          SEL_DIV_HI:   div_hi_q <= cfg_data;
          SEL_PRESCALE: pre_q    <= cfg_data;
          default: ;
        endcase
      end
    end
  end

  assign div_raw = {div_hi_q, div_lo_q};
  assign div_eff = (div_raw == '0) ? DIV_W'(1) : div_raw;
  assign pre_eff = (pre_q < PRE_UNITY) ? PRE_UNITY : pre_q;
  assign pre_clr = cfg_wr && (sel == SEL_PRESCALE);

  frac_prescaler #(.PRE_W(BYTE_W), .FRAC_W(FRAC_W)) u_pre (
    .clk(clk), .rst(rst), .clr(pre_clr), .limit(pre_eff), .ce_o(ce)
  );

  div_counter #(.DIV_W(DIV_W)) u_div (
    .clk(clk), .rst(rst), .ce(ce), .reload(reload_q), .div_val(div_eff),
    .tick_now(tick_now), .tick_o(os_tick)
  );

  baud_strobe #(.OVS(OVS)) u_baud (
    .clk(clk), .rst(rst), .clr(reload_q), .tick_now(tick_now), .baud_o(baud_stb)
  );

  // R8: the bit-rate strobe lands on a tick
  a_r8_baud_on_tick: assert property (@(posedge clk) disable iff (rst)
    baud_stb |-> os_tick);
  // R7: divisor one passes every enable straight through
  a_r7_unity_divisor: assert property (@(posedge clk) disable iff (rst)
    (ce && div_eff == DIV_W'(1) && !reload_q) |=> os_tick);
  // R1: outputs are quiet in the first cycle after reset
  a_r1_quiet_after_reset: assert property (@(posedge clk)
    $past(rst) |-> (!os_tick && !baud_stb));
endmodule

// File: tb/test_baud_tick_gen.sv
module test_baud_tick_gen;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       cfg_wr = 1'b0;
  logic [1:0] cfg_sel = 2'd3;
  logic [7:0] cfg_data = '0;
  logic       os_tick, baud_stb;

  int checks = 0;
  int fails  = 0;
  int cyc    = 0;

  always #5 clk = ~clk;

  baud_tick_gen i_baud_tick_gen (
    .clk(clk), .rst(rst), .cfg_wr(cfg_wr), .cfg_sel(cfg_sel),
    .cfg_data(cfg_data), .os_tick(os_tick), .baud_stb(baud_stb)
  );

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      checks++; fails++;
      $display("FAIL watchdog: actual %0d cycles expected below 150000", cyc);
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  function automatic int gap_lo(int d, int p); return (d * p) / 8; endfunction
  function automatic int gap_hi(int d, int p); return (d * p + 7) / 8; endfunction

  task automatic check(string req, int act, int exp_lo, int exp_hi);
    checks++;
    if (act < exp_lo || act > exp_hi) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d..%0d", req, act, exp_lo, exp_hi);
    end
  endtask

  task automatic cfg_write(logic [1:0] s, logic [7:0] d);
    @(negedge clk);
    cfg_wr = 1'b1; cfg_sel = s; cfg_data = d;
    @(negedge clk);
    cfg_wr = 1'b0; cfg_sel = 2'd3;
  endtask

  task automatic set_div(int d);
    cfg_write(2'd0, 8'(d));
    cfg_write(2'd1, 8'(d >> 8));
  endtask

  task automatic wait_tick();
    do @(negedge clk); while (!os_tick);
  endtask

  task automatic next_gap(output int n);
    n = 0;
    do begin @(negedge clk); n++; end while (!os_tick);
  endtask

  task automatic window_count(int len, output int n);
    n = 0;
    for (int i = 0; i < len; i++) begin
      @(negedge clk);
      if (os_tick) n++;
    end
  endtask

  initial begin
    int g, n, k, d, p;
    void'($urandom(32'd1311));

    // R1: reset state
    repeat (3) @(negedge clk);
    check("R1 tick low in reset", int'(os_tick), 0, 0);
    check("R1 baud low in reset", int'(baud_stb), 0, 0);
    rst = 1'b0;
    repeat (3) @(negedge clk);
    n = 0;
    for (int i = 0; i < 4; i++) begin @(negedge clk); if (os_tick) n++; end
    check("R1 default tick every cycle", n, 4, 4);

    // R2: integer division
    cfg_write(2'd2, 8'd8);
    set_div(7);
    wait_tick(); next_gap(g); check("R2 gap D=7", g, 7, 7);
    next_gap(g); check("R2 gap D=7 repeat", g, 7, 7);

    // R3: high byte participates
    set_div(259);
    wait_tick(); next_gap(g); check("R3 gap D=259", g, 259, 259);

    // R4: reload timing
    cfg_write(2'd1, 8'd0);
    cfg_write(2'd0, 8'd12);
    next_gap(n); check("R4 first tick after write", n, 13, 13);
    cfg_write(2'd0, 8'd5);
    next_gap(n); check("R4 first tick after write D=5", n, 6, 6);

    // R9: ignored select keeps phase
    set_div(10);
    wait_tick();
    n = 0;
    repeat (3) begin @(negedge clk); n++; end
    cfg_wr = 1'b1; cfg_sel = 2'd3; cfg_data = 8'hFF;
    @(negedge clk); n++;
    cfg_wr = 1'b0;
    while (!os_tick) begin @(negedge clk); n++; end
    check("R9 gap unchanged by select 3", n, 10, 10);
    next_gap(g); check("R9 period unchanged", g, 10, 10);

    // R6: prescaler clamp
    cfg_write(2'd2, 8'd3);
    set_div(6);
    wait_tick(); next_gap(g); check("R6 code 3 acts as 8", g, 6, 6);

    // R7: divisor 0 and 1
    set_div(0);
    wait_tick(); next_gap(g); check("R7 divisor 0 as 1", g, 1, 1);
    cfg_write(2'd2, 8'd20);
    set_div(1);
    wait_tick(); window_count(20, n); check("R7 D=1 P=20 window", n, 8, 8);
    wait_tick(); next_gap(g); check("R7 D=1 P=20 gap", g, 2, 3);

    // R8: baud strobe
    cfg_write(2'd2, 8'd8);
    set_div(3);
    k = 0;
    do begin @(negedge clk); if (os_tick) k++; end while (!baud_stb);
    check("R8 first strobe at tick 16", k, 16, 16);
    check("R8 strobe on tick", int'(os_tick), 1, 1);
    k = 0;
    do begin @(negedge clk); if (os_tick) k++; end while (!baud_stb);
    check("R8 strobe every 16 ticks", k, 16, 16);

    // R5: directed fractional case, then random
    cfg_write(2'd2, 8'd255);
    set_div(2);
    wait_tick(); window_count(510, n); check("R5 P=255 window", n, 8, 8);
    for (int it = 0; it < 10; it++) begin
      d = 1 + int'($urandom_range(39));
      p = 8 + int'($urandom_range(52));
      cfg_write(2'd2, 8'(p));
      set_div(d);
      wait_tick(); window_count(d * p, n);
      check("R5 random window", n, 8, 8);
      wait_tick(); next_gap(g);
      check("R5 random gap", g, gap_lo(d, p), gap_hi(d, p));
    end

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule